// File: doc/BRIEF.md
# Single-Issue Integer Instruction Executor

This block runs one 32-bit instruction at a time from a small load/store instruction subset. It takes an instruction word and its program counter when idle, and decodes the word. It reads operands from a 32-entry register file and forms one of three things: an arithmetic result, a memory address or a branch target. Results go back into the register file, and each completion is reported with a one-cycle pulse that names the class of instruction that finished.

Loads and stores do not touch any local memory. The address and store data are handed to a cache-side request port, and the block waits there until the cache acknowledges. For a load, the returned word is written into the destination register on the acknowledging edge. The next program counter is presented together with each completion pulse. The surrounding fetch logic uses it to choose the next instruction word.

Top module: `insn_exec_core`

## Requirements
- R1: After reset, `done`, `memRd` and `memWr` are low and every register in the file reads as zero.
- R2: `instrValid` is sampled only while the block is idle; an instruction offered while a load or store waits for `memAck` is dropped and leaves no trace in the registers or outputs.
- R3: An instruction with bits 31:26 = 000000, bits 10:6 = 00000 and bits 5:0 = 100000 writes the 32-bit wrapped sum of registers [25:21] and [20:16] into register [15:11].
- R4: Opcode 100011 puts register [25:21] plus the sign-extended bits 15:0 on `memAddr`, raises `memRd` from the cycle after acceptance until `memAck`, and writes `memRdata` at the acknowledging edge into register [20:16].
- R5: Opcode 101011 puts the same kind of address on `memAddr`, puts register [20:16] on `memWdata`, raises `memWr` until `memAck`, and writes no register.
- R6: Opcode 000100 branches when its two source registers are equal, and opcode 000101 branches when they differ. A taken branch gives `pcNext` = PC+4 + (sign-extended bits 15:0 shifted left by 2). A branch that is not taken gives PC+4.
- R7: Opcode 001111 writes bits 15:0 of the word into bits 31:16 of register [20:16] and clears bits 15:0.
- R8: Register 0 always reads as zero; add, load-upper and load writes aimed at it are dropped.
- R9: `done` is a one-cycle pulse with `doneClass` 00 for arithmetic/branch, 01 for load and 10 for store. It rises at the second clock edge after acceptance for class 00, and at the edge that samples `memAck` for loads and stores. `pcNext` is PC+4 for every non-branch.
- R10: Any other opcode, and any opcode-000000 word that is not the add pattern, writes no register and completes as class 00 with `pcNext` = PC+4.
- R11: `memRd` and `memWr` are never high together; while waiting for `memAck`, the active strobe and `memAddr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Offers `instrWord` and `pcIn` for execution |
| instrWord | input | 32 | Instruction word from the instruction register |
| pcIn | input | 32 | Address of the offered instruction |
| memAck | input | 1 | Cache acknowledges the pending read or write |
| memRdata | input | 32 | Load word from the memory data register, valid with `memAck` |
| memAddr | output | 32 | Byte address of the load or store |
| memWdata | output | 32 | Store data |
| memRd | output | 1 | Load request, held until `memAck` |
| memWr | output | 1 | Store request, held until `memAck` |
| pcNext | output | 32 | Next program counter, valid with `done` |
| done | output | 1 | Completion pulse |
| doneClass | output | 2 | Class of the completed instruction |

## Verification
The hardest situation to reach from the ports is a second instruction offered while a load or store is stalled on the acknowledge. If that word were taken, it would overwrite the decoded state partway through the access. The bench holds `memAck` low for several cycles and offers a load-upper to register 31 during the wait. It then checks that the access address, strobe and completion class do not change, and reads register 31 back through a store to show it was never written. Register contents are observed only through store data, so every register is read back by a store with base register 0 and offset 0. This is done after random mixes in which register indices are drawn from a narrow range, so that source and destination registers often coincide and register 0 is often the target.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam int INSN_W = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] OP_LUI   = 6'b001111;
  localparam logic [5:0] FN_ADD   = 6'b100000;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_STORE = 2'b10
  } opClassT;

  // strobes from control to datapath
  typedef struct packed {
    logic irLoad;    // capture instruction and PC
    logic aluWb;     // execute-cycle writeback / branch resolve
    logic memLatch;  // capture address and store data
    logic loadWb;    // write returned load word
    logic pcUpd;     // update next-PC register
  } strobeT;

endpackage

// File: rtl/exec_dpath.sv
module exec_dpath
  import exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobeT              stb,
  input  logic [INSN_W-1:0]   instrWord,
  input  logic [XLEN-1:0]     pcIn,
  input  logic [XLEN-1:0]     loadData,
  output opClassT             opClass,
  output logic [XLEN-1:0]     memAddr,
  output logic [XLEN-1:0]     memWdata,
  output logic [XLEN-1:0]     pcNext
);

  localparam int NREGS = 1 << REG_AW;

  logic [INSN_W-1:0] irReg;
  logic [XLEN-1:0]   pcReg;
  logic [XLEN-1:0]   regFile [NREGS];

  logic [5:0]        opc, funct;
  logic [4:0]        shamt;
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, wbIdx;
  logic [15:0]       imm;
  logic [XLEN-1:0]   rsVal, rtVal, immSext, sumVal, effAddr, seqPc, brTarget, luiVal, wbVal;
  logic              isAdd, isLui, isBeq, isBne, takeBr, wbEn;

  assign opc   = irReg[31:26];
  assign rsIdx = irReg[25:21];
  assign rtIdx = irReg[20:16];
  assign rdIdx = irReg[15:11];
  assign shamt = irReg[10:6];
  assign funct = irReg[5:0];
  assign imm   = irReg[15:0];

  // operand read, register 0 hardwired
  assign rsVal = (rsIdx == '0) ? '0 : regFile[rsIdx];
  assign rtVal = (rtIdx == '0) ? '0 : regFile[rtIdx];

  assign immSext  = {{(XLEN-16){imm[15]}}, imm};
  assign sumVal   = rsVal + rtVal;
  assign effAddr  = rsVal + immSext;
  assign seqPc    = pcReg + XLEN'(4);
  assign brTarget = seqPc + (immSext << 2);
  assign luiVal   = XLEN'({imm, 16'h0000});

  assign isAdd = (opc == OP_RTYPE) && (funct == FN_ADD) && (shamt == 5'd0);
  assign isLui = (opc == OP_LUI);
  assign isBeq = (opc == OP_BEQ);
  assign isBne = (opc == OP_BNE);
  assign takeBr = (isBeq && (rsVal == rtVal)) || (isBne && (rsVal != rtVal));

  always_comb begin
    unique case (opc)
      OP_LW:   opClass = CLS_LOAD;
      OP_SW:   opClass = CLS_STORE;
      default: opClass = CLS_ALU;
    endcase
  end

  always_comb begin
    wbEn  = isAdd || isLui;
    wbIdx = isAdd ? rdIdx : rtIdx;
    wbVal = isAdd ? sumVal : luiVal;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irReg <= '0;
      pcReg <= '0;
    end else if (stb.irLoad) begin
      irReg <= instrWord;
      pcReg <= pcIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regFile[i] <= '0;
    end else if (stb.aluWb && wbEn && (wbIdx != '0)) begin
      regFile[wbIdx] <= wbVal;
    end else if (stb.loadWb && (rtIdx != '0)) begin
      regFile[rtIdx] <= loadData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      memAddr  <= '0;
      memWdata <= '0;
    end else if (stb.memLatch) begin
      memAddr  <= effAddr;
      memWdata <= rtVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pcNext <= '0;
    else if (stb.pcUpd) pcNext <= (stb.aluWb && takeBr) ? brTarget : seqPc;
  end

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regFile[0] == '0);

  // R7
  lui_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.aluWb && isLui && (rtIdx != '0)) |=> (regFile[$past(rtIdx)][15:0] == 16'h0000));

  // R3
  add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.aluWb && isAdd && (rdIdx != '0)) |=> (regFile[$past(rdIdx)] == $past(rsVal) + $past(rtVal)));

endmodule

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    instrValid,
  input  logic    memAck,
  input  opClassT opClass,
  output strobeT  stb,
  output logic    memRd,
  output logic    memWr,
  output logic    done,
  output opClassT doneClass
);

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_MEM} stateT;

  stateT state, stateNxt;
  logic  inIdle, inExec, inMem, isMemOp;

  assign inIdle  = (state == ST_IDLE);
  assign inExec  = (state == ST_EXEC);
  assign inMem   = (state == ST_MEM);
  assign isMemOp = (opClass != CLS_ALU);

  always_comb begin
    stb.irLoad   = inIdle && instrValid;
    stb.aluWb    = inExec && !isMemOp;
    stb.memLatch = inExec && isMemOp;
    stb.loadWb   = inMem && memAck && (opClass == CLS_LOAD);
    stb.pcUpd    = (inExec && !isMemOp) || (inMem && memAck);
  end

  assign memRd = inMem && (opClass == CLS_LOAD);
  assign memWr = inMem && (opClass == CLS_STORE);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (instrValid) stateNxt = ST_EXEC;
      ST_EXEC: stateNxt = isMemOp ? ST_MEM : ST_IDLE;
      ST_MEM:  if (memAck) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      doneClass <= CLS_ALU;
    end else begin
      state <= stateNxt;
      done  <= stb.pcUpd;
      if (stb.pcUpd) doneClass <= opClass;
    end
  end

  // R11
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(memRd && memWr));

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((memRd || memWr) && !memAck) |=> ($stable(memRd) && $stable(memWr)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memRd && memAck) |=> (done && (doneClass == CLS_LOAD)));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inMem && !memAck) |=> inMem);

endmodule

// File: rtl/insn_exec_core.sv
module insn_exec_core
  import exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instrValid,
  input  logic [31:0]       instrWord,
  input  logic [XLEN-1:0]   pcIn,
  input  logic              memAck,
  input  logic [XLEN-1:0]   memRdata,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN-1:0]   memWdata,
  output logic              memRd,
  output logic              memWr,
  output logic [XLEN-1:0]   pcNext,
  output logic              done,
  output logic [1:0]        doneClass
);

  strobeT  stb;
  opClassT opClass;
  opClassT doneCls;

  exec_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .instrValid (instrValid),
    .memAck     (memAck),
    .opClass    (opClass),
    .stb        (stb),
    .memRd      (memRd),
    .memWr      (memWr),
    .done       (done),
    .doneClass  (doneCls)
  );

  exec_dpath #(.XLEN(XLEN)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .instrWord (instrWord),
    .pcIn      (pcIn),
    .loadData  (memRdata),
    .opClass   (opClass),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .pcNext    (pcNext)
  );

  assign doneClass = doneCls;

endmodule

// File: tb/sim_insn_exec_core.sv
`timescale 1ns/1ps
module sim_insn_exec_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] pcIn = '0;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;
  logic [31:0] memAddr, memWdata, pcNext;
  logic        memRd, memWr, done;
  logic [1:0]  doneClass;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] model [32];

  always #2.5 clk = ~clk;

  insn_exec_core u0 (
    .clk(clk), .rst_n(rst_n), .instrValid(instrValid), .instrWord(instrWord),
    .pcIn(pcIn), .memAck(memAck), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memRd(memRd), .memWr(memWr), .pcNext(pcNext),
    .done(done), .doneClass(doneClass)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic int clsOf(input logic [31:0] w);
    if (w[31:26] == 6'b100011) return 1;
    if (w[31:26] == 6'b101011) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] expPc(input logic [31:0] w, input logic [31:0] pc);
    logic [31:0] a, b;
    a = model[w[25:21]];
    b = model[w[20:16]];
    if ((w[31:26] == 6'b000100 && a == b) || (w[31:26] == 6'b000101 && a != b))
      return pc + 32'd4 + (sext(w[15:0]) << 2);
    return pc + 32'd4;
  endfunction

  function automatic string tagFor(input logic [31:0] w);
    case (w[31:26])
      6'b000000: return (w[5:0] == 6'b100000 && w[10:6] == 5'd0) ? "R3" : "R10";
      6'b100011: return "R4";
      6'b101011: return "R5";
      6'b000100, 6'b000101: return "R6";
      6'b001111: return "R7";
      default:   return "R10";
    endcase
  endfunction

  task automatic modelAlu(input logic [31:0] w);
    if (w[31:26] == 6'b000000 && w[5:0] == 6'b100000 && w[10:6] == 5'd0) begin
      if (w[15:11] != 5'd0) model[w[15:11]] = model[w[25:21]] + model[w[20:16]];
    end else if (w[31:26] == 6'b001111) begin
      if (w[20:16] != 5'd0) model[w[20:16]] = {w[15:0], 16'h0000};
    end
  endtask

  task automatic runInstr(input logic [31:0] w, input logic [31:0] pc, input int ackWait,
                          input logic [31:0] ld, input bit poke, input string tag);
    int cls;
    logic [31:0] ea, wd, ep;
    cls = clsOf(w);
    ea  = model[w[25:21]] + sext(w[15:0]);
    wd  = model[w[20:16]];
    ep  = expPc(w, pc);
    @(negedge clk);
    chk(done == 1'b0, "R9", 32'(done), 32'd0);
    instrValid = 1'b1; instrWord = w; pcIn = pc;
    @(negedge clk);
    instrValid = 1'b0; instrWord = $urandom;
    if (cls == 0) begin
      @(negedge clk);
      chk(done == 1'b1, tag, 32'(done), 32'd1);
      chk(doneClass == 2'b00, "R9", 32'(doneClass), 32'd0);
      chk(pcNext == ep, tag, pcNext, ep);
      modelAlu(w);
    end else begin
      @(negedge clk);
      chk(memRd == (cls == 1) && memWr == (cls == 2), "R11", {30'd0, memRd, memWr}, 32'(cls == 1 ? 2 : 1));
      chk(memAddr == ea, tag, memAddr, ea);
      if (cls == 2) chk(memWdata == wd, tag, memWdata, wd);
      for (int k = 0; k < ackWait; k++) begin
        if (poke) begin
          instrValid = 1'b1;
          instrWord = itype(6'b001111, 0, 31, 16'hDEAD);
        end
        @(negedge clk);
        chk(!done && (memRd || memWr) && memAddr == ea, poke ? "R2" : "R11", memAddr, ea);
      end
      instrValid = 1'b0;
      memAck = 1'b1; memRdata = ld;
      @(negedge clk);
      memAck = 1'b0; memRdata = $urandom;
      chk(done == 1'b1, tag, 32'(done), 32'd1);
      chk(doneClass == 2'(cls), "R9", 32'(doneClass), 32'(cls));
      chk(pcNext == pc + 32'd4, "R9", pcNext, pc + 32'd4);
      if (cls == 1 && w[20:16] != 5'd0) model[w[20:16]] = ld;
    end
  endtask

  task automatic readReg(input int r, input string tag);
    runInstr(itype(6'b101011, 0, r, 16'h0000), 32'h0000_0200, 0, 32'd0, 1'b0, tag);
  endtask

  function automatic logic [31:0] genRand();
    int rs, rt, rd, sel;
    rs = (($urandom % 8) == 0) ? 31 : int'($urandom_range(0, 7));
    rt = int'($urandom_range(0, 7));
    rd = int'($urandom_range(0, 7));
    sel = int'($urandom_range(0, 8));
    case (sel)
      0, 1: return rtype(rs, rt, rd, 6'b100000);
      2:    return itype(6'b100011, rs, rt, 16'($urandom));
      3:    return itype(6'b101011, rs, rt, 16'($urandom));
      4:    return itype(6'b000100, rs, rt, 16'($urandom));
      5:    return itype(6'b000101, rs, rt, 16'($urandom));
      6:    return itype(6'b001111, rs, rt, 16'($urandom));
      7:    return itype(6'b001000, rs, rt, 16'($urandom));
      default: return rtype(rs, rt, rd, 6'b100010);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!done && !memRd && !memWr, "R1", {29'd0, done, memRd, memWr}, 32'd0);
    readReg(1, "R1");
    readReg(17, "R1");
    readReg(31, "R1");

    // R7 load upper
    runInstr(itype(6'b001111, 0, 1, 16'hFFFF), 32'h0000_0010, 0, 0, 1'b0, "R7");
    readReg(1, "R7");
    // R3 add with carry out of bit 31
    runInstr(rtype(1, 1, 3, 6'b100000), 32'h0000_0014, 0, 0, 1'b0, "R3");
    readReg(3, "R3");
    runInstr(itype(6'b001111, 0, 4, 16'h8000), 32'h0000_0018, 0, 0, 1'b0, "R7");
    runInstr(rtype(4, 4, 5, 6'b100000), 32'h0000_001C, 0, 0, 1'b0, "R3");
    readReg(5, "R3");
    // R8 writes to register 0 dropped
    runInstr(rtype(1, 1, 0, 6'b100000), 32'h0000_0020, 0, 0, 1'b0, "R8");
    runInstr(itype(6'b001111, 0, 0, 16'h1234), 32'h0000_0024, 0, 0, 1'b0, "R8");
    runInstr(itype(6'b100011, 0, 0, 16'h0040), 32'h0000_0028, 1, 32'hCAFE_F00D, 1'b0, "R8");
    readReg(0, "R8");
    // R4 load with negative offset and wait cycles
    runInstr(itype(6'b100011, 1, 6, 16'hFFFC), 32'h0000_002C, 3, 32'h1234_5678, 1'b0, "R4");
    readReg(6, "R4");
    // R2 instruction offered during store wait
    runInstr(itype(6'b101011, 0, 6, 16'h0008), 32'h0000_0030, 3, 0, 1'b1, "R5");
    readReg(31, "R2");
    // R6 branches
    runInstr(itype(6'b000100, 0, 0, 16'hFFFD), 32'h0000_0100, 0, 0, 1'b0, "R6");
    runInstr(itype(6'b000101, 0, 0, 16'h0007), 32'h0000_0100, 0, 0, 1'b0, "R6");
    runInstr(itype(6'b000101, 1, 0, 16'h0005), 32'h0000_0100, 0, 0, 1'b0, "R6");
    runInstr(itype(6'b000100, 1, 3, 16'h0005), 32'h0000_0100, 0, 0, 1'b0, "R6");
    // R10 unsupported words
    runInstr(itype(6'b001000, 1, 7, 16'h0011), 32'h0000_0040, 0, 0, 1'b0, "R10");
    readReg(7, "R10");
    runInstr(rtype(1, 1, 8, 6'b100010), 32'h0000_0044, 0, 0, 1'b0, "R10");
    readReg(8, "R10");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      w = genRand();
      runInstr(w, {20'd0, 10'($urandom), 2'b00}, int'($urandom_range(0, 3)),
               $urandom, (($urandom % 4) == 0), tagFor(w));
    end
    for (int r = 0; r < 32; r++) readReg(r, "R5");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule